// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four independent down-counters behind a simple APB-style register bus. Each channel counts down by one on every prescaled tick while it is enabled. On reaching zero it raises its own interrupt bit. On the next tick it wraps to the all-ones value, reloads a stored period, or stops, depending on its mode. Software can start a new count at once by writing the load register. It can also stage a new period through the background-load register, which leaves the running count alone and only takes effect at the next wrap.

A shared interrupt block keeps one sticky raw bit per channel (bit n belongs to channel n), a mask, and the masked status. A single interrupt output is the OR of the masked bits. Each channel runs a three-state machine. OFF means the enable bit is clear. RUN means it is counting. SPENT means a one-shot count has finished. The transitions are: OFF→RUN when enabled. RUN→OFF and SPENT→OFF when disabled. RUN→SPENT on a one-shot tick taken at zero. SPENT→RUN on a load write or when one-shot mode is turned off.

Top module: `tmr_unit`

## Requirements
- R1: After reset every register reads zero. The shared registers sit at 0x00 (mask), 0x04 (raw status), 0x08 (masked status) and 0x0C (clear, reads zero). Channel n uses base 0x10+0x10*n, with load at +0x0, current value at +0x4, control at +0x8 and background load at +0xC. Any other offset reads zero.
- R2: Control bit 7 enables the channel. With prescale 00 the counter drops by one on each clock edge, starting with the first edge after the enabling write.
- R3: Control bits 3:2 choose the prescaler. 01 gives one tick every 16 running cycles, and 10 (or 11) gives one tick every 256.
- R4: When control bit 1 is 0 the counter is 16 bits wide. Upper bits are ignored, the value reads masked to 16 bits, and a wrap goes to 0xFFFF. When bit 1 is 1 the counter is 32 bits wide.
- R5: In free-running mode (bits 6 and 0 both 0), the tick taken at zero loads the all-ones value of the selected width.
- R6: In periodic mode (bit 6 = 1, bit 0 = 0), the tick taken at zero loads the stored reload value.
- R7: In one-shot mode (bit 0 = 1) the counter stays at zero. The enable bit stays set and the channel's raw bit stays set.
- R8: The tick that takes the counter from 1 to 0 sets raw bit n. A wrap does not set it.
- R9: Writing the load register sets the counter and the reload value, and clears the prescaler.
- R10: Writing the background-load register changes only the reload value, which the load and background-load offsets both read. The running count is unaffected.
- R11: Masked status equals raw AND mask. The interrupt output is high when any masked bit is set.
- R12: Writing 1 to bit n of the clear register clears raw bit n. A zero event in the same cycle wins, and the bit stays set.
- R13: While the enable bit is 0, the counter and its prescaler hold their values. Counting resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A software clear of a raw bit and a new zero event on the same channel can land on the same clock edge. The bench starts channel 0 free-running from 5 at a known edge and times a clear write so that its access edge is the fifth counting edge. It then expects the raw bit to read back as set. A second clear, issued with no event pending, must then read back as cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CB_ONESHOT  = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_PRE_LO   = 2;
    localparam int CB_PRE_HI   = 3;
    localparam int CB_PERIODIC = 6;
    localparam int CB_ENA      = 7;
    localparam int CTRL_W      = 8;
    localparam int PRE_W       = 8;

    localparam logic [1:0] W_LOAD = 2'd0;
    localparam logic [1:0] W_VAL  = 2'd1;
    localparam logic [1:0] W_CTRL = 2'd2;
    localparam logic [1:0] W_BG   = 2'd3;

    localparam logic [1:0] W_MASK = 2'd0;
    localparam logic [1:0] W_RAW  = 2'd1;
    localparam logic [1:0] W_MIS  = 2'd2;
    localparam logic [1:0] W_CLR  = 2'd3;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RUN   = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              load_we,
    input  logic              bg_we,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              event_o
);
    localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] ONE         = {{(CNT_W-1){1'b0}}, 1'b1};

    ch_state_e         state_q, state_d;
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [CNT_W-1:0]  cnt_q, reload_q, wmask, cnt_m;
    logic [PRE_W-1:0]  pre_q;
    logic              tick, running;

    assign ctrl_d  = ctrl_we ? wdata[CTRL_W-1:0] : ctrl_q;
    assign wmask   = ctrl_q[CB_WIDE] ? '1 : NARROW_MASK;
    assign cnt_m   = cnt_q & wmask;
    assign running = (state_q == CH_RUN);

    always_comb begin
        unique case (ctrl_q[CB_PRE_HI:CB_PRE_LO])
            2'b00:   tick = 1'b1;
            2'b01:   tick = (pre_q[3:0] == 4'hF);
            default: tick = (pre_q == '1);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:   if (ctrl_d[CB_ENA]) state_d = CH_RUN;
            CH_RUN: begin
                if (!ctrl_d[CB_ENA])
                    state_d = CH_OFF;
                else if (tick && !load_we && ctrl_q[CB_ONESHOT] && (cnt_m == '0))
                    state_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (!ctrl_d[CB_ENA])                       state_d = CH_OFF;
                else if (load_we || !ctrl_d[CB_ONESHOT])   state_d = CH_RUN;
            end
            default:  state_d = CH_OFF;
        endcase
    end

    // datapath outputs of the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cnt_q    <= '0;
            reload_q <= '0;
            pre_q    <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (load_we || bg_we) reload_q <= wdata;
            if (load_we) begin
                cnt_q <= wdata;
                pre_q <= '0;
            end else if (running) begin
                pre_q <= pre_q + 1'b1;
                if (tick) begin
                    if (cnt_m != '0)               cnt_q <= cnt_m - ONE;
                    else if (ctrl_q[CB_ONESHOT])   cnt_q <= '0;
                    else if (ctrl_q[CB_PERIODIC])  cnt_q <= reload_q & wmask;
                    else                           cnt_q <= wmask;
                end
            end
        end
    end

    assign event_o  = running && tick && !load_we && (cnt_m == ONE);
    assign ctrl_o   = ctrl_q;
    assign cnt_o    = cnt_m;
    assign reload_o = reload_q;

    p_hold_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) && !load_we |=> $stable(cnt_q) && $stable(pre_q));
    p_spent_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SPENT) && !load_we |=> $stable(cnt_q));
    p_event_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> (cnt_o == '0));
    p_off_no_event_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_RUN) |-> !event_o);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic              irq_o
);
    localparam int BLK_W = ADDR_W - 4;

    logic             wr_en, aligned;
    logic [BLK_W-1:0] blk;
    logic [1:0]       word;
    logic [NCH-1:0]   mask_q, raw_q, evt, clr;
    logic [NCH-1:0]   ctrl_we, load_we, bg_we;
    logic [CTRL_W-1:0] ctrl_v [NCH];
    logic [CNT_W-1:0]  cnt_v  [NCH];
    logic [CNT_W-1:0]  rel_v  [NCH];

    assign aligned = (paddr[1:0] == 2'b00);
    assign blk     = paddr[ADDR_W-1:4];
    assign word    = paddr[3:2];
    assign wr_en   = psel && penable && pwrite && aligned;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit        = wr_en && (blk == BLK_W'(i + 1));
        assign ctrl_we[i] = hit && (word == W_CTRL);
        assign load_we[i] = hit && (word == W_LOAD);
        assign bg_we[i]   = hit && (word == W_BG);

        tmr_chan #(.CNT_W(CNT_W), .NARROW_W(16)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (ctrl_we[i]),
            .load_we  (load_we[i]),
            .bg_we    (bg_we[i]),
            .wdata    (pwdata),
            .ctrl_o   (ctrl_v[i]),
            .cnt_o    (cnt_v[i]),
            .reload_o (rel_v[i]),
            .event_o  (evt[i])
        );

        p_event_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> raw_q[i]);
        p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !evt[i] |=> !raw_q[i]);
        p_raw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            raw_q[i] && !clr[i] |=> raw_q[i]);
    end

    assign clr = (wr_en && blk == '0 && word == W_CLR) ? pwdata[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_en && blk == '0 && word == W_MASK) mask_q <= pwdata[NCH-1:0];
            raw_q <= (raw_q & ~clr) | evt;
        end
    end

    assign irq_o = |(raw_q & mask_q);

    always_comb begin
        prdata = '0;
        if (aligned) begin
            if (blk == '0) begin
                unique case (word)
                    W_MASK:  prdata = CNT_W'(mask_q);
                    W_RAW:   prdata = CNT_W'(raw_q);
                    W_MIS:   prdata = CNT_W'(raw_q & mask_q);
                    default: prdata = '0;
                endcase
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (blk == BLK_W'(i + 1)) begin
                        unique case (word)
                            W_VAL:   prdata = cnt_v[i];
                            W_CTRL:  prdata = CNT_W'(ctrl_v[i]);
                            default: prdata = rel_v[i];
                        endcase
                    end
                end
            end
        end
    end

    p_irq_needs_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_unit u_tmr_unit (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [7:0]  ctrl;
        logic [31:0] load;
        logic [31:0] bg;
        logic [15:0] n;
        logic [31:0] exp_val;
        logic        exp_raw;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h82, 32'd100,     32'd0,  16'd40,  32'd60,        1'b0}, // R2
        '{2'd1, 8'h82, 32'd10,      32'd0,  16'd10,  32'd0,         1'b1}, // R8
        '{2'd2, 8'h82, 32'd5,       32'd0,  16'd6,   32'hFFFF_FFFF, 1'b1}, // R5
        '{2'd3, 8'h80, 32'd3,       32'd0,  16'd4,   32'h0000_FFFF, 1'b1}, // R4
        '{2'd0, 8'hC2, 32'd4,       32'd20, 16'd7,   32'd18,        1'b1}, // R6
        '{2'd1, 8'h83, 32'd3,       32'd0,  16'd10,  32'd0,         1'b1}, // R7
        '{2'd2, 8'h86, 32'd50,      32'd0,  16'd40,  32'd48,        1'b0}, // R3
        '{2'd3, 8'h8A, 32'd10,      32'd0,  16'd600, 32'd8,         1'b0}, // R3
        '{2'd0, 8'h80, 32'h12345,   32'd0,  16'd5,   32'h2340,      1'b0}  // R4
    };

    function automatic logic [7:0] ca(input int ch, input int off);
        return 8'(8'h10 + 8'h10 * ch + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        paddr = a;
        #1 d = prdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        waitn(3);
        rst_n = 1'b1;
        waitn(1);

        // R1 reset state and map
        rd(8'h00, d); chk("R1 mask", d, 0);
        rd(8'h04, d); chk("R1 raw", d, 0);
        rd(ca(0, 4), d); chk("R1 value", d, 0);
        rd(ca(2, 8), d); chk("R1 ctrl", d, 0);
        chk("R1 irq", 32'(irq_o), 0);

        foreach (VECS[k]) begin
            vec_t v;
            v = VECS[k];
            wr(ca(v.ch, 8), 32'h0);
            wr(8'h0C, 32'(1) << v.ch);
            wr(ca(v.ch, 0), v.load);
            wr(ca(v.ch, 12), v.bg);
            wr(ca(v.ch, 8), 32'(v.ctrl));
            waitn(int'(v.n));
            rd(ca(v.ch, 4), d);
            chk($sformatf("R2-table value vec%0d", k), d, v.exp_val);
            rd(8'h04, d);
            chk($sformatf("R8 table raw vec%0d", k), 32'(d[v.ch]), 32'(v.exp_raw));
        end

        // R7 one-shot keeps enable, stays at zero
        rd(ca(1, 8), d); chk("R7 ctrl kept", d, 32'h83);
        rd(ca(1, 4), d); chk("R7 still zero", d, 0);

        // R11 mask and combined output
        wr(8'h00, 32'h2);
        wr(ca(1, 8), 32'h0);
        wr(8'h0C, 32'h2);
        chk("R11 irq low after clear", 32'(irq_o), 0);
        wr(ca(1, 0), 32'd2);
        wr(ca(1, 8), 32'h82);
        waitn(2);
        #1 chk("R11 irq high", 32'(irq_o), 1);
        rd(8'h08, d); chk("R11 masked status", d, 32'h2);
        wr(8'h00, 32'h0);
        #1 chk("R11 irq masked off", 32'(irq_o), 0);

        // R12 clear and event on the same edge
        wr(ca(0, 8), 32'h0);
        wr(8'h0C, 32'h1);
        wr(ca(0, 0), 32'd5);
        wr(ca(0, 8), 32'h82);
        waitn(3);
        wr(8'h0C, 32'h1);
        rd(8'h04, d); chk("R12 event wins", 32'(d[0]), 1);
        wr(8'h0C, 32'h1);
        rd(8'h04, d); chk("R12 clear", 32'(d[0]), 0);

        // R10 background load deferred, R9 load sets counter
        wr(ca(2, 8), 32'h0);
        wr(ca(2, 0), 32'd8);
        wr(ca(2, 8), 32'hC2);
        waitn(2);
        wr(ca(2, 12), 32'd3);
        rd(ca(2, 4), d); chk("R10 count unaffected", d, 4);
        rd(ca(2, 12), d); chk("R10 reload readback", d, 3);
        rd(ca(2, 0), d); chk("R10 load offset reads reload", d, 3);
        waitn(5);
        rd(ca(2, 4), d); chk("R10 reload used at wrap", d, 3);
        wr(ca(2, 0), 32'd77);
        rd(ca(2, 4), d); chk("R9 load direct", d, 77);

        // R13 disable holds counter and prescaler
        wr(ca(3, 8), 32'h0);
        wr(ca(3, 0), 32'd100);
        wr(ca(3, 8), 32'h86);
        waitn(10);
        wr(ca(3, 8), 32'h06);
        rd(ca(3, 4), d); chk("R13 held at disable", d, 100);
        waitn(20);
        rd(ca(3, 4), d); chk("R13 still held", d, 100);
        wr(ca(3, 8), 32'h86);
        waitn(3);
        rd(ca(3, 4), d); chk("R13 prescaler resumed", d, 100);
        waitn(1);
        rd(ca(3, 4), d); chk("R13 tick after resume", d, 99);

        // R1 unmapped and clear offset read zero
        rd(8'h50, d); chk("R1 unmapped", d, 0);
        rd(8'h0C, d); chk("R1 clear reads zero", d, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule